// File: doc/BRIEF.md
# GCD Peripheral on an APB Register Interface

This block wraps a small greatest-common-divisor engine behind an APB slave so that a processor can drive it like memory. Software enables the engine and writes an operand pair. It then waits for the result, either by polling a status word or by taking an interrupt, and reads the result back. The engine has a valid/ready handshake on each side, and the block generates both handshakes from side effects of register accesses. Writing the operand register launches one computation. Reading the result register releases the engine, which otherwise stalls holding its result.

The interrupt can be turned off, or it can run in one of two modes. In level mode it is raised for as long as a result is waiting. In edge mode it is a single-cycle pulse when a result appears. In both modes the acknowledge is a read of the result register.

Top module: `gcd_apb_periph`

## Requirements
- R1: Register selection uses only PADDR[3:2]: 0 = control (read/write), 1 = status (read-only), 2 = operands (read/write), 3 = result (read-only). Every register reads 0 after reset.
- R2: Control keeps only bits [2:0]: bit 0 = engine enable, bit 1 = interrupt enable, bit 2 = interrupt mode (0 level, 1 edge). The operand register keeps only bits [15:0]. All other bits of every register read 0.
- R3: A write to the status or result register changes neither of them.
- R4: While control bit 0 is clear, the engine is held in reset: status reads 0, any computation in progress is dropped, and the result register returns to 0.
- R5: Status bit 1 shows that the engine can accept operands and bit 0 shows that a result is waiting. Both are registered copies of the engine's handshake outputs.
- R6: Each operand write with the engine ready starts exactly one computation of gcd(a, b), with a = bits [15:8] and b = bits [7:0]. The result appears in result bits [7:0]. gcd(x, 0) = gcd(0, x) = x and gcd(0, 0) = 0.
- R7: The operand-valid and result-ready strobes to the engine each last exactly one cycle per APB transfer.
- R8: Once a result is waiting, the engine holds it unchanged and refuses new operands until the result register is read. That read returns the engine to ready.
- R9: The interrupt output stays low whenever control bit 1 is clear.
- R10: In level mode the interrupt is high while a result waits and falls after the result register is read.
- R11: In edge mode the interrupt is high for exactly one cycle per result.
- R12: PREADY is always high. PRDATA is 0 except during the access phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and engine clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete, tied high |
| irq | output | 1 | Result interrupt |

## Verification
The assertions check on every cycle the timing properties. Each strobe lasts one cycle. The status word trails the engine by exactly one clock. The engine is idle while disabled. A waiting result holds steady until it is released. The interrupt stays off when disabled, and an edge-mode pulse never lasts two cycles. Only the bench's scenarios can show that the result is numerically correct across random and degenerate operand pairs, including zeros and coprime worst cases. The same holds for three more behaviours: read-only writes leave the registers untouched, disabling mid-computation clears the result, and in each interrupt mode the acknowledge read lowers the line.

// File: rtl/gcd_periph_pkg.sv
package gcd_periph_pkg;
  localparam int OPW   = 8;
  localparam int CTRLW = 3;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_OPND = 2'd2;
  localparam logic [1:0] SEL_RSLT = 2'd3;

  typedef enum logic [1:0] {ENG_IDLE, ENG_BUSY, ENG_DONE} eng_state_e;

  // One subtractive Euclid step: the larger value loses the smaller.
  function automatic logic [2*OPW-1:0] gcd_step(input logic [OPW-1:0] x,
                                                 input logic [OPW-1:0] y);
    if (x > y) return {x - y, y};
    else       return {x, y - x};
  endfunction
endpackage

// File: rtl/gcd_core.sv
module gcd_core
  import gcd_periph_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] opa,
  input  logic [OPW-1:0] opb,
  output logic           in_ready,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OPW-1:0] result
);
  eng_state_e     state;
  logic [OPW-1:0] x, y;
  logic           run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      x     <= '0;
      y     <= '0;
      run   <= 1'b0;
    end else begin
      run <= 1'b1;
      unique case (state)
        ENG_IDLE: if (in_valid && run) begin
          x     <= opa;
          y     <= opb;
          state <= ENG_BUSY;
        end
        ENG_BUSY: begin
          if (x == '0) begin
            x     <= y;
            state <= ENG_DONE;
          end else if (y == '0 || x == y) begin
            state <= ENG_DONE;
          end else begin
            {x, y} <= gcd_step(x, y);
          end
        end
        ENG_DONE: if (out_ready) state <= ENG_IDLE;
        default:  state <= ENG_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ENG_IDLE) && run;
  assign out_valid = (state == ENG_DONE);
  assign result    = x;

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result))); // R8
endmodule

// File: rtl/gcd_apb_regs.sv
module gcd_apb_regs
  import gcd_periph_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic [CTRLW-1:0]  ctrl,
  output logic [OPW-1:0]    opa,
  output logic [OPW-1:0]    opb,
  output logic              opnd_strobe,
  output logic              rslt_strobe,
  input  logic              eng_in_ready,
  input  logic              eng_out_valid,
  input  logic [OPW-1:0]    eng_result
);
  localparam int OPNDW = 2 * OPW;

  logic [1:0]       sel;
  logic             access, wr_en, rd_en;
  logic             wr_opnd, rd_rslt;
  logic [OPNDW-1:0] opnd_q;
  logic [1:0]       stat_q;
  logic [OPW-1:0]   rslt_q;

  assign sel     = paddr[ADDR_W-1 -: 2];
  assign access  = psel && penable;
  assign wr_en   = access && pwrite;
  assign rd_en   = access && !pwrite;
  assign wr_opnd = wr_en && (sel == SEL_OPND);
  assign rd_rslt = rd_en && (sel == SEL_RSLT);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl        <= '0;
      opnd_q      <= '0;
      stat_q      <= '0;
      rslt_q      <= '0;
      opnd_strobe <= 1'b0;
      rslt_strobe <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_CTRL) ctrl <= pwdata[CTRLW-1:0];
      if (wr_opnd) opnd_q <= pwdata[OPNDW-1:0];
      stat_q      <= {eng_in_ready, eng_out_valid};
      rslt_q      <= eng_result;
      opnd_strobe <= wr_opnd;
      rslt_strobe <= rd_rslt;
    end
  end

  assign opa = opnd_q[OPNDW-1:OPW];
  assign opb = opnd_q[OPW-1:0];

  always_comb begin
    prdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_CTRL: prdata[CTRLW-1:0] = ctrl;
        SEL_STAT: prdata[1:0]       = stat_q;
        SEL_OPND: prdata[OPNDW-1:0] = opnd_q;
        default:  prdata[OPW-1:0]   = rslt_q;
      endcase
    end
  end

  AST_OPND_STROBE_ONE: assert property (@(posedge pclk) disable iff (!presetn)
    opnd_strobe |=> !opnd_strobe); // R7
  AST_RSLT_STROBE_ONE: assert property (@(posedge pclk) disable iff (!presetn)
    rslt_strobe |=> !rslt_strobe); // R7
  AST_STATUS_TRAILS: assert property (@(posedge pclk) disable iff (!presetn)
    stat_q == $past({eng_in_ready, eng_out_valid})); // R5
endmodule

// File: rtl/gcd_irq.sv
module gcd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic out_valid,
  input  logic irq_en,
  input  logic edge_mode,
  output logic irq
);
  logic valid_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= out_valid;
  end

  assign rise = out_valid && !valid_q;
  assign irq  = irq_en && (edge_mode ? rise : out_valid);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R9
  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && edge_mode) |=> !(irq && edge_mode)); // R11
endmodule

// File: rtl/gcd_apb_periph.sv
module gcd_apb_periph
  import gcd_periph_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              irq
);
  logic [CTRLW-1:0] ctrl;
  logic [OPW-1:0]   opa, opb, eng_result;
  logic             opnd_strobe, rslt_strobe;
  logic             eng_in_ready, eng_out_valid;
  logic             eng_rst_n;

  assign pready    = 1'b1;
  assign eng_rst_n = presetn && ctrl[0];

  gcd_apb_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ctrl(ctrl), .opa(opa), .opb(opb),
    .opnd_strobe(opnd_strobe), .rslt_strobe(rslt_strobe),
    .eng_in_ready(eng_in_ready), .eng_out_valid(eng_out_valid),
    .eng_result(eng_result)
  );

  gcd_core u_core (
    .clk(pclk), .rst_n(eng_rst_n),
    .in_valid(opnd_strobe), .opa(opa), .opb(opb), .in_ready(eng_in_ready),
    .out_valid(eng_out_valid), .out_ready(rslt_strobe), .result(eng_result)
  );

  gcd_irq u_irq (
    .clk(pclk), .rst_n(presetn), .out_valid(eng_out_valid),
    .irq_en(ctrl[1]), .edge_mode(ctrl[2]), .irq(irq)
  );

  AST_HELD_WHEN_OFF: assert property (@(posedge pclk) disable iff (!presetn)
    !ctrl[0] |-> (!eng_in_ready && !eng_out_valid)); // R4
endmodule

// File: tb/sim_gcd_apb_periph.sv
`timescale 1ns/1ps
module sim_gcd_apb_periph;
  logic        clk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, irq;

  int checks = 0, fails = 0, irq_hits = 0;

  always #2.5 clk = ~clk;

  gcd_apb_periph u0 (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_hits++;

  function automatic logic [7:0] ref_gcd(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    #1 check("R12 prdata idle on write", prdata, 32'h0);
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    if (!pready) check("R12 pready", {31'b0, pready}, 32'h1);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_status(input int bitn);
    logic [31:0] s;
    for (int i = 0; i < 600; i++) begin
      apb_read(4'h4, s);
      if (s[bitn]) return;
    end
    check("R8 status poll timeout", 32'h0, 32'h1);
  endtask

  task automatic run_pair(input logic [7:0] a, input logic [7:0] b, input string req);
    logic [31:0] r;
    wait_status(1);
    apb_write(4'h8, {16'h0, a, b});
    wait_status(0);
    apb_read(4'hC, r);
    check(req, r, {24'h0, ref_gcd(a, b)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int unused;
    unused = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    presetn = 1;
    repeat (3) @(negedge clk);

    // R1 reset values, R4 disabled engine shows zero status
    for (int k = 0; k < 4; k++) begin
      apb_read(4'(k * 4), r);
      check("R1 reset value", r, 32'h0);
    end
    check("R12 pready high", {31'b0, pready}, 32'h1);
    check("R12 prdata idle", prdata, 32'h0);

    // R2 unmapped bits
    apb_write(4'h0, 32'hFFFF_FFF8);
    apb_read(4'h0, r);  check("R2 control width", r, 32'h0);
    apb_write(4'h0, 32'h1);
    repeat (3) @(negedge clk);
    apb_read(4'h4, r);  check("R5 status ready after enable", r, 32'h2);
    apb_write(4'h8, 32'hFFFF_FFFF);
    apb_read(4'h8, r);  check("R2 operand width", r, 32'h0000_FFFF);
    wait_status(0);
    apb_read(4'h4, r);  check("R5 status valid", r, 32'h1);
    apb_write(4'h8, 32'h0000_0102);     // refused while result waits
    apb_read(4'hC, r);  check("R8 result held", r, 32'hFF);
    repeat (3) @(negedge clk);
    apb_read(4'h4, r);  check("R8 ready after read", r, 32'h2);

    // R3 read-only writes ignored
    apb_write(4'h4, 32'hFFFF_FFFF);
    apb_read(4'h4, r);  check("R3 status write ignored", r, 32'h2);
    apb_write(4'hC, 32'h0000_0011);
    apb_read(4'hC, r);  check("R3 result write ignored", r, 32'hFF);

    // R6 directed corners
    run_pair(8'd0,   8'd0,   "R6 gcd(0,0)");
    run_pair(8'd0,   8'd45,  "R6 gcd(0,x)");
    run_pair(8'd60,  8'd0,   "R6 gcd(x,0)");
    run_pair(8'd255, 8'd1,   "R6 gcd(255,1)");
    run_pair(8'd1,   8'd255, "R6 gcd(1,255)");
    run_pair(8'd144, 8'd144, "R6 gcd(x,x)");
    run_pair(8'd12,  8'd18,  "R6 gcd(12,18)");
    // R7 R6 random pairs: each write yields exactly one result
    for (int i = 0; i < 40; i++)
      run_pair(8'($urandom), 8'($urandom), "R6 R7 random pair");

    // R9 interrupt disabled
    irq_hits = 0;
    run_pair(8'd21, 8'd14, "R6 gcd irq off");
    check("R9 no interrupt when disabled", irq_hits, 0);

    // R10 level mode
    apb_write(4'h0, 32'h3);
    wait_status(1);
    apb_write(4'h8, {16'h0, 8'd48, 8'd36});
    wait_status(0);
    @(negedge clk); check("R10 level high while waiting", {31'b0, irq}, 32'h1);
    apb_read(4'hC, r);  check("R10 result", r, 32'd12);
    repeat (3) @(negedge clk);
    check("R10 level cleared by read", {31'b0, irq}, 32'h0);

    // R11 edge mode
    apb_write(4'h0, 32'h7);
    wait_status(1);
    irq_hits = 0;
    apb_write(4'h8, {16'h0, 8'd200, 8'd3});
    wait_status(0);
    repeat (4) @(negedge clk);
    check("R11 one pulse per result", irq_hits, 1);
    apb_read(4'hC, r);  check("R11 result", r, 32'd1);
    repeat (3) @(negedge clk);
    check("R11 no pulse on acknowledge", irq_hits, 1);

    // R4 disable mid-computation
    apb_write(4'h0, 32'h1);
    wait_status(1);
    apb_write(4'h8, {16'h0, 8'd255, 8'd1});
    apb_write(4'h0, 32'h0);
    apb_read(4'h4, r);  check("R4 status zero while disabled", r, 32'h0);
    apb_read(4'hC, r);  check("R4 result cleared", r, 32'h0);
    apb_write(4'h0, 32'h1);
    repeat (3) @(negedge clk);
    apb_read(4'h4, r);  check("R4 ready after re-enable", r, 32'h2);
    apb_read(4'h8, r);  check("R1 operands kept", r, 32'h0000_FF01);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule